// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Unit

The block holds two independent countdown timers and a small interrupt unit, reached over a plain 32-bit register bus. Each timer has a reload register and a control register. The control register sets a load, hold or run operation and picks a tick source from four external tick-enable inputs. Reloading on expiry makes a timer periodic.

When a timer expires it sets its own raw interrupt bit. Software reads the raw bits and the masked bits, sets a per-timer mask, and clears bits through an acknowledge register that stores nothing. A single interrupt line goes high while any masked bit is set. A free-running cycle counter can also be read. The bus accepts full-word accesses only. A narrower access is dropped and answered with an error pulse.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every readable register returns 0, both timers are stopped and `irq` is low.
- R2: Control bits [1:0] set the operation. 0 copies the reload value into the count and stops the timer. 1 stops the timer. 2 starts the timer. A control write with code 3 is ignored, so the stored control word and the timer keep their previous state.
- R3: Control bits [4:2] pick the tick source. Codes 4, 5, 6 and 7 use `tick_en[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 never advance the count.
- R4: A running timer decrements once for each cycle in which its selected tick is high. A tick at count 0 is an expiry: it reloads the count from the reload register, so the period is reload+1 ticks.
- R5: An expiry of timer 0 sets raw bit 0, and an expiry of timer 1 sets raw bit 1. The raw bits read at offset 0x50.
- R6: A write to offset 0x4C clears every raw bit written as 1. That offset always reads 0.
- R7: The mask at offset 0x48 is readable and writable in bits [1:0]. Offset 0x54 reads raw AND mask. `irq` is high exactly while that value is nonzero.
- R8: When an expiry and an acknowledge of the same bit land in the same cycle, the bit ends up set.
- R9: Offset 0x38 reads a counter that advances by one on every clock.
- R10: An access with `req_size` other than 2 (a full word) is not performed. `acc_err` is high for the one cycle after it, and the read data is 0.
- R11: Read data is registered and is valid the cycle after the request. The register offsets are: reload at 0x00 and 0x10, count at 0x04 and 0x14, and control at 0x08 and 0x18, for timers 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_size | input | 2 | Access size code, 2 = 32-bit |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| acc_err | output | 1 | One-cycle pulse after a narrow access |
| tick_en | input | 4 | External tick-enable sources |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupted count shows up on the next read of the count register. It also shows up as an expiry that comes one or more ticks early or late: raw bit 0 or 1 is set at the wrong tick and `irq` rises or stays low in the following cycle. A wrong raw or mask state shows on `irq` as soon as the clock edge after the offending write. Ignored accesses (code 3 operations, narrow writes, ticks from unselected sources) are checked by reading back the control, mask or count register right after them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

    typedef struct packed {
        logic [2:0] src;
        tmr_op_e    op;
    } tmr_ctrl_t;

    localparam int NUM_TMR = 2;
    localparam int NUM_SRC = 4;

    localparam logic [7:0] A_RLD0  = 8'h00;
    localparam logic [7:0] A_CNT0  = 8'h04;
    localparam logic [7:0] A_CTL0  = 8'h08;
    localparam logic [7:0] A_RLD1  = 8'h10;
    localparam logic [7:0] A_CNT1  = 8'h14;
    localparam logic [7:0] A_CTL1  = 8'h18;
    localparam logic [7:0] A_TIME  = 8'h38;
    localparam logic [7:0] A_MASK  = 8'h48;
    localparam logic [7:0] A_ACK   = 8'h4C;
    localparam logic [7:0] A_RAW   = 8'h50;
    localparam logic [7:0] A_MSKD  = 8'h54;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    function automatic logic pick_tick(input logic [2:0] src,
                                       input logic [NUM_SRC-1:0] ticks);
        logic hit;
        hit = 1'b0;
        if (src[2]) hit = ticks[src[1:0]];
        return hit;
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rld_we,
    input  logic               ctl_we,
    input  logic [31:0]        wdata,
    input  logic [NUM_SRC-1:0] tick_en,
    output logic [CNT_W-1:0]   rld_q,
    output logic [CNT_W-1:0]   cnt_q,
    output tmr_ctrl_t          ctl_q,
    output logic               expire
);
    tmr_ctrl_t new_ctl;
    logic      run_q;
    logic      ctl_take;
    logic      adv;

    assign new_ctl  = tmr_ctrl_t'(wdata[4:0]);
    assign ctl_take = ctl_we && (new_ctl.op != OP_BAD);
    assign adv      = run_q && pick_tick(ctl_q.src, tick_en);
    assign expire   = adv && !ctl_take && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q <= '0;
            cnt_q <= '0;
            ctl_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (rld_we) rld_q <= wdata[CNT_W-1:0];
            if (ctl_take) begin
                ctl_q <= new_ctl;
                unique case (new_ctl.op)
                    OP_LOAD: begin
                        cnt_q <= rld_q;
                        run_q <= 1'b0;
                    end
                    OP_HOLD: run_q <= 1'b0;
                    OP_RUN:  run_q <= 1'b1;
                    default: run_q <= run_q;
                endcase
            end else if (adv) begin
                cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mask_we,
    input  logic               ack_we,
    input  logic [NUM_TMR-1:0] wbits,
    input  logic [NUM_TMR-1:0] expire,
    output logic [NUM_TMR-1:0] raw_q,
    output logic [NUM_TMR-1:0] mask_q,
    output logic               irq
);
    logic [NUM_TMR-1:0] clr;

    assign clr = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr) | expire;
            if (mask_we) mask_q <= wbits;
        end
    end

    assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TIME_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata,
    output logic        acc_err,
    input  logic [3:0]  tick_en,
    output logic        irq
);
    localparam logic [7:0] TMR_STRIDE = 8'h10;

    logic                good;
    logic                wr;
    logic                rd;
    logic [NUM_TMR-1:0]  expire;
    logic [NUM_TMR-1:0]  raw_q;
    logic [NUM_TMR-1:0]  mask_q;
    logic [CNT_W-1:0]    rld_v [NUM_TMR];
    logic [CNT_W-1:0]    cnt_v [NUM_TMR];
    tmr_ctrl_t           ctl_v [NUM_TMR];
    logic [TIME_W-1:0]   time_q;
    logic [31:0]         rd_mux;
    tmr_ctrl_t           ctrl0_q;

    assign good = req_valid && (req_size == SIZE_WORD);
    assign wr   = good && req_write;
    assign rd   = good && !req_write;

    genvar g;
    generate
        for (g = 0; g < NUM_TMR; g++) begin : g_tmr
            localparam logic [7:0] BASE = TMR_STRIDE * g;
            tmr_channel #(.CNT_W(CNT_W)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .rld_we  (wr && (req_addr == BASE + A_RLD0)),
                .ctl_we  (wr && (req_addr == BASE + A_CTL0)),
                .wdata   (req_wdata),
                .tick_en (tick_en),
                .rld_q   (rld_v[g]),
                .cnt_q   (cnt_v[g]),
                .ctl_q   (ctl_v[g]),
                .expire  (expire[g])
            );
        end
    endgenerate

    assign ctrl0_q = ctl_v[0];

    tmr_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (wr && (req_addr == A_MASK)),
        .ack_we  (wr && (req_addr == A_ACK)),
        .wbits   (req_wdata[NUM_TMR-1:0]),
        .expire  (expire),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    always_comb begin
        rd_mux = '0;
        unique case (req_addr)
            A_RLD0:  rd_mux = 32'(rld_v[0]);
            A_CNT0:  rd_mux = 32'(cnt_v[0]);
            A_CTL0:  rd_mux = 32'(ctl_v[0]);
            A_RLD1:  rd_mux = 32'(rld_v[1]);
            A_CNT1:  rd_mux = 32'(cnt_v[1]);
            A_CTL1:  rd_mux = 32'(ctl_v[1]);
            A_TIME:  rd_mux = 32'(time_q);
            A_MASK:  rd_mux = 32'(mask_q);
            A_RAW:   rd_mux = 32'(raw_q);
            A_MSKD:  rd_mux = 32'(raw_q & mask_q);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
            time_q    <= '0;
        end else begin
            time_q    <= time_q + 1'b1;
            rsp_rdata <= rd ? rd_mux : '0;
            acc_err   <= req_valid && (req_size != SIZE_WORD);
        end
    end
endmodule

// File: rtl/dual_tick_timer_chk.sv
module dual_tick_timer_chk
    import tmr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_addr,
    input logic [1:0]  req_size,
    input logic [31:0] req_wdata,
    input logic        acc_err,
    input logic        irq,
    input logic [1:0]  raw_q,
    input logic [1:0]  mask_q,
    input logic [1:0]  expire,
    input tmr_ctrl_t   ctrl0_q
);
    logic narrow;
    logic ack0;
    assign narrow = req_valid && (req_size != SIZE_WORD);
    assign ack0   = req_valid && req_write && (req_size == SIZE_WORD) &&
                    (req_addr == A_ACK) && req_wdata[0];

    AST_NARROW_ERR: assert property (@(posedge clk) disable iff (rst)
        narrow |=> acc_err); // R10
    AST_NARROW_NO_MASK: assert property (@(posedge clk) disable iff (rst)
        narrow |=> $stable(mask_q)); // R10
    AST_BAD_OP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == SIZE_WORD &&
         req_addr == A_CTL0 && req_wdata[1:0] == 2'd3) |=> $stable(ctrl0_q)); // R2
    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (rst)
        expire[0] |=> raw_q[0]); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack0 && !expire[0]) |=> !raw_q[0]); // R6
    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw_q != 2'b00)); // R7
endmodule

bind dual_tick_timer dual_tick_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .acc_err   (acc_err),
    .irq       (irq),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .expire    (expire),
    .ctrl0_q   (ctrl0_q)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        acc_err;
    logic [3:0]  tick_en = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_tick_timer dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .acc_err(acc_err), .tick_en(tick_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_size = 2;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = 2;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
    endtask

    task automatic tick(input int idx);
        @(negedge clk);
        tick_en[idx] = 1'b1;
        @(negedge clk);
        tick_en = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", 32'(irq), 0);
        rd(8'h00, v); check("R1 rld0", v, 0);
        rd(8'h14, v); check("R1 cnt1", v, 0);
        rd(8'h08, v); check("R1 ctl0", v, 0);
        rd(8'h48, v); check("R1 mask", v, 0);
        rd(8'h50, v); check("R1 raw", v, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(8'h00, 32'd3);
        rd(8'h00, v); check("R11 rld0", v, 3);
        wr(8'h08, 32'h10);                    // src 4, load
        rd(8'h04, v); check("R2 load", v, 3);
        rd(8'h08, v); check("R11 ctl0", v, 32'h10);
        wr(8'h08, 32'h12);                    // src 4, run
        for (int i = 1; i <= 3; i++) begin
            tick(0);
            rd(8'h04, v); check("R4 count", v, 32'(3 - i));
        end
        rd(8'h50, v); check("R4 no early expiry", v, 0);
        tick(0);
        rd(8'h50, v); check("R5 raw bit0", v, 1);
        rd(8'h04, v); check("R4 reload", v, 3);
    endtask

    task automatic t_hold_bad();
        logic [31:0] v;
        wr(8'h08, 32'h11);                    // hold
        tick(0);
        rd(8'h04, v); check("R2 hold", v, 3);
        wr(8'h08, 32'h1F);                    // op 3
        rd(8'h08, v); check("R2 op3 ignored", v, 32'h11);
        tick(0);
        rd(8'h04, v); check("R2 op3 no run", v, 3);
    endtask

    task automatic t_source();
        logic [31:0] v;
        wr(8'h10, 32'd5);
        wr(8'h18, 32'h04);                    // src 1, load
        wr(8'h18, 32'h06);                    // src 1, run
        for (int i = 0; i < 4; i++) tick(i);
        rd(8'h14, v); check("R3 src1 frozen", v, 5);
        wr(8'h18, 32'h1E);                    // src 7, run
        tick(0);
        rd(8'h14, v); check("R3 unselected", v, 5);
        tick(3);
        rd(8'h14, v); check("R3 src7 tick3", v, 4);
        wr(8'h18, 32'h1D);                    // hold
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R7 masked off", 32'(irq), 0);
        wr(8'h48, 32'h1);
        check("R7 irq high", 32'(irq), 1);
        rd(8'h54, v); check("R7 masked read", v, 1);
        rd(8'h48, v); check("R7 mask read", v, 1);
        wr(8'h4C, 32'h1);
        check("R6 irq low after ack", 32'(irq), 0);
        rd(8'h50, v); check("R6 raw cleared", v, 0);
        rd(8'h4C, v); check("R6 ack reads 0", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(8'h00, 32'd0);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);                    // count 0, running
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h4C; req_wdata = 1; req_size = 2;
        tick_en[0] = 1'b1;
        @(negedge clk);
        req_valid = 0; req_write = 0; tick_en = '0;
        rd(8'h50, v); check("R8 expiry wins", v, 1);
        wr(8'h08, 32'h11);
        wr(8'h4C, 32'h1);
        rd(8'h50, v); check("R6 clear after", v, 0);
    endtask

    task automatic t_time();
        logic [31:0] a, b;
        rd(8'h38, a);
        rd(8'h38, b);
        check("R9 time step", b - a, 2);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h48; req_wdata = 32'h3; req_size = 2'd1;
        @(negedge clk);
        req_valid = 0; req_write = 0; req_size = 2;
        check("R10 err pulse", 32'(acc_err), 1);
        @(negedge clk);
        check("R10 err one cycle", 32'(acc_err), 0);
        rd(8'h48, v); check("R10 mask unchanged", v, 1);
        @(negedge clk);
        req_valid = 1; req_addr = 8'h48; req_size = 2'd0;
        @(negedge clk);
        req_valid = 0; req_size = 2;
        check("R10 narrow read data", rsp_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_periodic();
        t_hold_bad();
        t_source();
        t_irq();
        t_collide();
        t_time();
        t_narrow();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule